// File: doc/BRIEF.md
# Processor Register File with Interrupt Frame Sequencer

This block holds the programmer-visible state of an 8-bit accumulator machine: two accumulators (A, B), a 16-bit index register (X), a 16-bit stack pointer (SP), a 16-bit program counter (PC) and an 8-bit flag register (CC). A surrounding control unit asks for one operation at a time by raising `op_valid` with a code on `op_sel` while the block is idle. Four register transfers finish in one cycle: SP to X, X to SP, A to CC and CC to A.

Two multi-cycle sequences move the whole register frame across a byte-wide memory port. The interrupt-entry sequence writes all registers below the stack pointer, sets the interrupt mask and fetches a new PC from a fixed vector pair. The interrupt-return sequence pulls the same frame back, so every register can be preset from a prepared stack image. The memory port reads combinationally: `mem_rdata` must be valid in the same cycle that `mem_rd` and `mem_addr` are presented.

Top module: `regframe_unit`

## Requirements
- R1: While `rst` is high at a clock edge, A, B, X, SP and PC become 0, CC becomes 8'hD0, and `busy` and `done` are low after that edge.
- R2: Code 3'd1 (SP to X) accepted while idle loads X with SP+1 at the next edge. For example, SP 16'h1EFE gives X 16'h1EFF. SP is unchanged.
- R3: Code 3'd2 (X to SP) accepted while idle loads SP with X−1 at the next edge. For example, X 16'h1B00 gives SP 16'h1AFF.
- R4: Code 3'd3 (A to CC) loads CC with A, with CC bits 7 and 6 forced to 1. For example, 5A gives DA, FF gives FF and 00 gives C0. A is unchanged, and CC bits 7:6 read 1 at all times after reset.
- R5: Code 3'd4 (CC to A) loads A with CC in one cycle and leaves CC unchanged.
- R6: Code 3'd5 (interrupt entry) writes seven bytes, one per cycle, each to the current SP, and SP decrements after each write. The byte order is PC[7:0], PC[15:8], X[7:0], X[15:8], A, B, CC. SP ends 7 below its start.
- R7: After stacking, interrupt entry sets CC bit 4. It then reads PC[15:8] from 16'hFFFA and PC[7:0] from 16'hFFFB.
- R8: Code 3'd6 (interrupt return) reads seven bytes, each from SP+1, and SP increments after each read. The bytes load CC, B, A, X[15:8], X[7:0], PC[15:8] and PC[7:0] in that order, with CC bits 7:6 forced to 1. SP ends 7 above its start.
- R9: `busy` is high for exactly 9 cycles during interrupt entry and for exactly 7 cycles during interrupt return. `done` is high for the single cycle after `busy` falls. `mem_rd` and `mem_wr` are never high together.
- R10: A request made while `busy` is high is ignored. A request with code 3'd0 or 3'd7 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation request, sampled while idle |
| op_sel | input | 3 | Operation code |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| busy | output | 1 | A frame sequence is running |
| done | output | 1 | One-cycle pulse when a frame sequence ends |
| obs_a | output | 8 | Accumulator A |
| obs_b | output | 8 | Accumulator B |
| obs_x | output | 16 | Index register |
| obs_sp | output | 16 | Stack pointer |
| obs_pc | output | 16 | Program counter |
| obs_ccr | output | 8 | Flag register |

## Verification
Each single-cycle transfer takes effect at the first edge after the request, so the bench samples its result at the next falling edge.

For a frame sequence, the bench counts the falling edges at which `busy` is high. Interrupt entry must give 9 and interrupt return must give 7. `done` must be high at the first falling edge where `busy` is low and low again one edge later. Register contents are compared only at that point.

Stack writes are logged at the rising edge where `mem_wr` is high, and their addresses and data are checked once the sequence has ended.

// File: rtl/regframe_pkg.sv
package regframe_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_SP2X = 3'd1,
        OP_X2SP = 3'd2,
        OP_A2CC = 3'd3,
        OP_CC2A = 3'd4,
        OP_SWI  = 3'd5,
        OP_RTI  = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC,
        ST_PULL
    } seq_e;

    // Slot numbering is the push order; the pull order is its reverse.
    typedef enum logic [2:0] {
        SLOT_PCL = 3'd0,
        SLOT_PCH = 3'd1,
        SLOT_XL  = 3'd2,
        SLOT_XH  = 3'd3,
        SLOT_A   = 3'd4,
        SLOT_B   = 3'd5,
        SLOT_CC  = 3'd6
    } slot_e;

    localparam int FRAME_BYTES = 7;

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] x;
        logic [15:0] sp;
        logic [15:0] pc;
        logic [7:0]  cc;
    } regs_t;

endpackage

// File: rtl/rf_xfer.sv
module rf_xfer
    import regframe_pkg::*;
#(
    parameter logic [7:0] CC_FIXED = 8'hC0
) (
    input  regs_t      cur,
    input  logic [2:0] op,
    output regs_t      nxt,
    output logic       hit
);

    always_comb begin
        nxt = cur;
        hit = 1'b1;
        case (op_e'(op))
            OP_SP2X: nxt.x  = cur.sp + 16'd1;
            OP_X2SP: nxt.sp = cur.x - 16'd1;
            OP_A2CC: nxt.cc = cur.a | CC_FIXED;
            OP_CC2A: nxt.a  = cur.cc;
            default: hit    = 1'b0;
        endcase
    end

endmodule

// File: rtl/rf_slot_mux.sv
module rf_slot_mux
    import regframe_pkg::*;
(
    input  regs_t      cur,
    input  logic [2:0] slot,
    output logic [7:0] byte_o
);

    logic [7:0] frame [FRAME_BYTES];

    always_comb begin
        frame[SLOT_PCL] = cur.pc[7:0];
        frame[SLOT_PCH] = cur.pc[15:8];
        frame[SLOT_XL]  = cur.x[7:0];
        frame[SLOT_XH]  = cur.x[15:8];
        frame[SLOT_A]   = cur.a;
        frame[SLOT_B]   = cur.b;
        frame[SLOT_CC]  = cur.cc;
        byte_o = (int'(slot) < FRAME_BYTES) ? frame[slot] : 8'h00;
    end

endmodule

// File: rtl/rf_slot_load.sv
module rf_slot_load
    import regframe_pkg::*;
#(
    parameter logic [7:0] CC_FIXED = 8'hC0
) (
    input  regs_t      cur,
    input  logic [2:0] slot,
    input  logic [7:0] byte_i,
    output regs_t      nxt
);

    always_comb begin
        nxt = cur;
        case (slot_e'(slot))
            SLOT_PCL: nxt.pc[7:0]  = byte_i;
            SLOT_PCH: nxt.pc[15:8] = byte_i;
            SLOT_XL:  nxt.x[7:0]   = byte_i;
            SLOT_XH:  nxt.x[15:8]  = byte_i;
            SLOT_A:   nxt.a        = byte_i;
            SLOT_B:   nxt.b        = byte_i;
            SLOT_CC:  nxt.cc       = byte_i | CC_FIXED;
            default:  nxt          = cur;
        endcase
    end

endmodule

// File: rtl/regframe_unit.sv
module regframe_unit
    import regframe_pkg::*;
#(
    parameter logic [15:0] VEC_ADDR  = 16'hFFFA,
    parameter logic [7:0]  CC_FIXED  = 8'hC0,
    parameter logic [7:0]  CC_RESET  = 8'hD0,
    parameter int          IMASK_BIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_sel,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  mem_wdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        busy,
    output logic        done,
    output logic [7:0]  obs_a,
    output logic [7:0]  obs_b,
    output logic [15:0] obs_x,
    output logic [15:0] obs_sp,
    output logic [15:0] obs_pc,
    output logic [7:0]  obs_ccr
);

    localparam int              STEP_W    = $clog2(FRAME_BYTES);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FRAME_BYTES - 1);

    typedef struct packed {
        regs_t             r;
        seq_e              st;
        logic [STEP_W-1:0] step;
        logic              done;
    } core_t;

    core_t core_d, core_q;

    regs_t      xfer_nxt;
    logic       xfer_hit;
    logic [7:0] push_byte;
    regs_t      pull_nxt;
    logic [2:0] pull_slot;

    assign pull_slot = 3'(LAST_STEP - core_q.step);

    rf_xfer #(.CC_FIXED(CC_FIXED)) u_xfer (
        .cur (core_q.r),
        .op  (op_sel),
        .nxt (xfer_nxt),
        .hit (xfer_hit)
    );

    rf_slot_mux u_push (
        .cur    (core_q.r),
        .slot   (3'(core_q.step)),
        .byte_o (push_byte)
    );

    rf_slot_load #(.CC_FIXED(CC_FIXED)) u_pull (
        .cur    (core_q.r),
        .slot   (pull_slot),
        .byte_i (mem_rdata),
        .nxt    (pull_nxt)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_addr    = core_q.r.sp;
        mem_wdata   = push_byte;
        case (core_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    if (xfer_hit) begin
                        core_d.r = xfer_nxt;
                    end else if (op_sel == OP_SWI) begin
                        core_d.st   = ST_PUSH;
                        core_d.step = '0;
                    end else if (op_sel == OP_RTI) begin
                        core_d.st   = ST_PULL;
                        core_d.step = '0;
                    end
                end
            end
            ST_PUSH: begin
                mem_wr         = 1'b1;
                mem_addr       = core_q.r.sp;
                core_d.r.sp    = core_q.r.sp - 16'd1;
                if (core_q.step == LAST_STEP) begin
                    core_d.st              = ST_VEC;
                    core_d.step            = '0;
                    core_d.r.cc[IMASK_BIT] = 1'b1;
                end else begin
                    core_d.step = core_q.step + 1'b1;
                end
            end
            ST_VEC: begin
                mem_rd   = 1'b1;
                mem_addr = VEC_ADDR + 16'(core_q.step);
                if (core_q.step == '0) begin
                    core_d.r.pc[15:8] = mem_rdata;
                    core_d.step       = core_q.step + 1'b1;
                end else begin
                    core_d.r.pc[7:0] = mem_rdata;
                    core_d.st        = ST_IDLE;
                    core_d.step      = '0;
                    core_d.done      = 1'b1;
                end
            end
            ST_PULL: begin
                mem_rd      = 1'b1;
                mem_addr    = core_q.r.sp + 16'd1;
                core_d.r    = pull_nxt;
                core_d.r.sp = core_q.r.sp + 16'd1;
                if (core_q.step == LAST_STEP) begin
                    core_d.st   = ST_IDLE;
                    core_d.step = '0;
                    core_d.done = 1'b1;
                end else begin
                    core_d.step = core_q.step + 1'b1;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q      <= '0;
            core_q.r.cc <= CC_RESET;
            core_q.st   <= ST_IDLE;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy    = (core_q.st != ST_IDLE);
    assign done    = core_q.done;
    assign obs_a   = core_q.r.a;
    assign obs_b   = core_q.r.b;
    assign obs_x   = core_q.r.x;
    assign obs_sp  = core_q.r.sp;
    assign obs_pc  = core_q.r.pc;
    assign obs_ccr = core_q.r.cc;

endmodule

// File: rtl/rf_checker.sv
module rf_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_sel,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        busy,
    input logic        done,
    input logic [7:0]  obs_a,
    input logic [15:0] obs_x,
    input logic [15:0] obs_sp,
    input logic [7:0]  obs_ccr
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (obs_ccr == 8'hD0 && !busy && !done));

    assert_sp_to_x_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_valid && op_sel == 3'd1) |=> obs_x == $past(obs_sp) + 16'd1);

    assert_x_to_sp_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_valid && op_sel == 3'd2) |=> obs_sp == $past(obs_x) - 16'd1);

    assert_cc_reserved_R4: assert property (@(posedge clk) disable iff (rst)
        obs_ccr[7:6] == 2'b11);

    assert_cc_to_a_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_valid && op_sel == 3'd4) |=> (obs_a == $past(obs_ccr) && $stable(obs_ccr)));

    assert_push_addr_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_addr == obs_sp);

    assert_push_dec_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> obs_sp == $past(obs_sp) - 16'd1);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

bind regframe_unit rf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .busy     (busy),
    .done     (done),
    .obs_a    (obs_a),
    .obs_x    (obs_x),
    .obs_sp   (obs_sp),
    .obs_ccr  (obs_ccr)
);

// File: tb/sim_regframe_unit.sv
`timescale 1ns/1ps
module sim_regframe_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, busy, done;
    logic [7:0]  obs_a, obs_b, obs_ccr;
    logic [15:0] obs_x, obs_sp, obs_pc;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    regframe_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
        .obs_a(obs_a), .obs_b(obs_b), .obs_x(obs_x), .obs_sp(obs_sp),
        .obs_pc(obs_pc), .obs_ccr(obs_ccr)
    );

    logic [7:0]  mem [256];
    logic [15:0] wlog_addr [8];
    logic [7:0]  wlog_data [8];
    int          wcount = 0;

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            if (wcount < 8) begin
                wlog_addr[wcount] <= mem_addr;
                wlog_data[wcount] <= mem_wdata;
            end
            wcount <= wcount + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  cc;
        logic [7:0]  b;
        logic [7:0]  a;
        logic [15:0] x;
        logic [15:0] pc;
        logic [2:0]  op;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h33, 8'h5A, 16'h1B00, 16'h1234, 3'd2, 16'h1AFF},
        '{8'h3F, 8'h11, 8'hA5, 16'h1EF8, 16'h4321, 3'd2, 16'h1EF7},
        '{8'h15, 8'h22, 8'h5A, 16'h0042, 16'h2222, 3'd1, 16'h1EFF},
        '{8'h00, 8'h44, 8'h5A, 16'h2000, 16'h3000, 3'd3, 16'h00DA},
        '{8'h01, 8'h55, 8'hFF, 16'h2001, 16'h3001, 3'd3, 16'h00FF},
        '{8'h3F, 8'h66, 8'h00, 16'h2002, 16'h3002, 3'd3, 16'h00C0},
        '{8'h2B, 8'h77, 8'h77, 16'h2003, 16'h3003, 3'd4, 16'h00EB},
        '{8'h05, 8'h88, 8'h99, 16'h2004, 16'h3004, 3'd4, 16'h00C5}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic single_op(input logic [2:0] op);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op;
        @(negedge clk);
        op_valid = 1'b0;
        op_sel   = 3'd0;
    endtask

    // Starts a frame sequence; optionally requests X-to-SP throughout busy.
    task automatic run_seq(input logic [2:0] op, input logic interfere, output int cnt);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op;
        @(negedge clk);
        op_valid = interfere;
        op_sel   = 3'd2;
        cnt = 0;
        while (busy && cnt < 50) begin
            cnt++;
            @(negedge clk);
        end
        op_valid = 1'b0;
        op_sel   = 3'd0;
    endtask

    task automatic check_reset_state();
        chk("R1 a", 16'(obs_a), 16'h0000);
        chk("R1 b", 16'(obs_b), 16'h0000);
        chk("R1 x", obs_x, 16'h0000);
        chk("R1 sp", obs_sp, 16'h0000);
        chk("R1 pc", obs_pc, 16'h0000);
        chk("R1 ccr", 16'(obs_ccr), 16'h00D0);
        chk("R1 busy", 16'(busy), 16'h0000);
        chk("R1 done", 16'(done), 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] sp_m;
        logic [7:0]  base;
        int          cnt;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        sp_m = 16'h0000;
        for (int v = 0; v < NVEC; v++) begin
            base = sp_m[7:0];
            mem[8'(base + 8'd1)] = VECS[v].cc;
            mem[8'(base + 8'd2)] = VECS[v].b;
            mem[8'(base + 8'd3)] = VECS[v].a;
            mem[8'(base + 8'd4)] = VECS[v].x[15:8];
            mem[8'(base + 8'd5)] = VECS[v].x[7:0];
            mem[8'(base + 8'd6)] = VECS[v].pc[15:8];
            mem[8'(base + 8'd7)] = VECS[v].pc[7:0];
            run_seq(3'd6, 1'b0, cnt);
            chk("R9 return busy cycles", 16'(cnt), 16'd7);
            chk("R9 return done", 16'(done), 16'h0001);
            chk("R8 cc", 16'(obs_ccr), 16'(VECS[v].cc | 8'hC0));
            chk("R8 b", 16'(obs_b), 16'(VECS[v].b));
            chk("R8 a", 16'(obs_a), 16'(VECS[v].a));
            chk("R8 x", obs_x, VECS[v].x);
            chk("R8 pc", obs_pc, VECS[v].pc);
            chk("R8 sp", obs_sp, sp_m + 16'd7);
            sp_m = sp_m + 16'd7;
            single_op(VECS[v].op);
            case (VECS[v].op)
                3'd1: begin
                    chk("R2 x", obs_x, VECS[v].exp);
                    chk("R2 sp kept", obs_sp, sp_m);
                end
                3'd2: begin
                    chk("R3 sp", obs_sp, VECS[v].exp);
                    sp_m = VECS[v].exp;
                end
                3'd3: begin
                    chk("R4 ccr", 16'(obs_ccr), VECS[v].exp);
                    chk("R4 a kept", 16'(obs_a), 16'(VECS[v].a));
                end
                default: begin
                    chk("R5 a", 16'(obs_a), VECS[v].exp);
                    chk("R5 ccr kept", 16'(obs_ccr), VECS[v].exp);
                end
            endcase
        end

        // State now: a=C5 b=88 x=2004 pc=3004 cc=C5 sp=1F21
        single_op(3'd0);
        single_op(3'd7);
        chk("R10 a", 16'(obs_a), 16'h00C5);
        chk("R10 b", 16'(obs_b), 16'h0088);
        chk("R10 x", obs_x, 16'h2004);
        chk("R10 sp", obs_sp, 16'h1F21);
        chk("R10 pc", obs_pc, 16'h3004);
        chk("R10 ccr", 16'(obs_ccr), 16'h00C5);

        mem[8'hFA] = 8'hAB;
        mem[8'hFB] = 8'hCD;
        wcount = 0;
        run_seq(3'd5, 1'b1, cnt);
        chk("R9 entry busy cycles", 16'(cnt), 16'd9);
        chk("R9 entry done", 16'(done), 16'h0001);
        chk("R6 write count", 16'(wcount), 16'd7);
        begin
            logic [7:0] expd [7];
            expd = '{8'h04, 8'h30, 8'h04, 8'h20, 8'hC5, 8'h88, 8'hC5};
            for (int k = 0; k < 7; k++) begin
                chk("R6 push addr", wlog_addr[k], 16'h1F21 - 16'(k));
                chk("R6 push data", 16'(wlog_data[k]), 16'(expd[k]));
            end
        end
        chk("R6 sp end", obs_sp, 16'h1F1A);
        chk("R10 busy request ignored", obs_sp, 16'h1F1A);
        chk("R7 mask set", 16'(obs_ccr), 16'h00D5);
        chk("R7 vector pc", obs_pc, 16'hABCD);
        @(negedge clk);
        chk("R9 done one cycle", 16'(done), 16'h0000);

        run_seq(3'd6, 1'b0, cnt);
        chk("R9 return busy cycles", 16'(cnt), 16'd7);
        chk("R8 round trip pc", obs_pc, 16'h3004);
        chk("R8 round trip x", obs_x, 16'h2004);
        chk("R8 round trip a", 16'(obs_a), 16'h00C5);
        chk("R8 round trip b", 16'(obs_b), 16'h0088);
        chk("R8 round trip ccr", 16'(obs_ccr), 16'h00C5);
        chk("R8 round trip sp", obs_sp, 16'h1F21);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule